// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that a small processor core reaches through two byte-wide special-function registers. One register holds control bits and event flags. The other is a single data location. A write to the data location hands a byte to the transmitter. A read from it returns the last byte the receiver completed, never the shift register that is still filling. Each frame carries either eight data bits, or nine data bits when the ninth-bit mode is selected. Every frame has one start bit and one stop bit and is sent least significant bit first.

The bit timing comes from outside the block. The input `baud16_en` pulses once per sixteenth of a bit period. The transmitter counts sixteen pulses per bit. The receiver oversamples the line with the same pulses.

The receiver is double-buffered. A completed byte moves into a holding latch, so the next frame can start shifting in while software has not yet read the previous byte. A transmit-done flag and a receive-full flag each drive one combined interrupt request. Hardware only ever sets these flags. Software clears them.

Top module: `sfr_uart`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, the control register reads 0x00 and the data location reads 0x00.
- R2: Control register layout: bit0 TX_DONE, bit1 RX_FULL, bit2 TX_BIT9, bit3 RX_BIT9 (read-only), bit4 RX_ON, bit5 MODE9, bits 7:6 read 0. When `sfr_sel_data`=1 the data location is selected, and when it is 0 the control register is selected. With MODE9=0, a data write sends one frame on `txd`: a 0 start bit, 8 data bits LSB first, and a 1 stop bit, each lasting 16 `baud16_en` pulses.
- R3: With MODE9=1, the transmitted frame has 9 data bits. The ninth data bit equals TX_BIT9 at the time of the write.
- R4: TX_DONE is set at the end of each transmitted stop bit. RX_FULL is set when a received byte enters the latch. `irq` is 1 exactly when TX_DONE or RX_FULL is 1.
- R5: TX_DONE and RX_FULL stay set until a control write clears them. They do not drop on their own.
- R6: With RX_ON=1 and MODE9=0, a valid frame on `rxd` loads its 8 data bits into the latch. The data location then returns that byte.
- R7: With MODE9=1, the 9-bit frame's low 8 bits go to the latch and its ninth bit goes to RX_BIT9.
- R8: A second frame can be received while the first byte is still in the latch. Reads during that reception return the first byte. If RX_FULL is cleared before the second frame ends, the latch then holds the second byte.
- R9: If RX_FULL is still 1 when a frame ends, the new byte is discarded. The latch keeps the old byte and RX_FULL stays 1.
- R10: A low pulse on `rxd` that is high again at the middle of the start bit is ignored. RX_FULL stays 0.
- R11: With RX_ON=0, frames on `rxd` are ignored. RX_FULL stays 0 and the latch is unchanged.
- R12: A data write while a frame is being sent is ignored. The frame in progress is unchanged and no further frame follows.
- R13: A frame whose stop bit is 0 is discarded. RX_FULL stays 0 and the latch is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud16_en | input | 1 | Pulse at 16 times the bit rate |
| sfr_sel_data | input | 1 | 1 selects the data location, 0 the control register |
| sfr_wr | input | 1 | Register write strobe, one cycle |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data of the selected register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined transmit/receive interrupt request |

## Verification
The hardest situation to reach from the ports is a byte arriving while an earlier byte still sits unread in the latch, split into its two outcomes: software frees the latch mid-frame, or software does not. The stimulus first lets one frame fill the latch. It then drives a second frame on `rxd` from a forked thread. The main thread reads the data location mid-frame and either clears RX_FULL or leaves it set. After the stop bit it checks which byte the latch holds. Glitches and bad stop bits are produced by holding `rxd` low for a short pulse or for the whole stop bit.

// File: rtl/sfr_uart_pkg.sv
package sfr_uart_pkg;

  // control register bit positions
  localparam int unsigned CB_TXDONE = 0;
  localparam int unsigned CB_RXFULL = 1;
  localparam int unsigned CB_TXB9   = 2;
  localparam int unsigned CB_RXB9   = 3;
  localparam int unsigned CB_RXON   = 4;
  localparam int unsigned CB_MODE9  = 5;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/sfr_uart_sync.sv
module sfr_uart_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sfr_uart_tx.sv
module sfr_uart_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              mode9,
  input  logic              bit9,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int unsigned SH_W  = DATA_W + 3;
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  logic [SH_W-1:0]  sh_q, sh_n, sh_shift;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n, done_q, done_n, txd_q, txd_n;

  assign sh_shift = sh_q >> 1;

  // next state: shifts in zeros, frame ends when shifter reaches zero
  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (load) begin
        sh_n   = mode9 ? {1'b1, bit9, load_data, 1'b0}
                       : {1'b0, 1'b1, load_data, 1'b0};
        cnt_n  = '0;
        busy_n = 1'b1;
      end
    end else if (tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_n = '0;
        sh_n  = sh_shift;
        if (sh_shift == '0) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    txd_n = busy_n ? sh_n[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      txd_q  <= txd_n;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;
  assign done = done_q;

  // R4: completion pulse only follows an active frame
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

  // R12: a write during a frame leaves the shifter alone
  a_r12_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load && !tick) |=> $stable(sh_q));

endmodule

// File: rtl/sfr_uart_rx.sv
module sfr_uart_rx
  import sfr_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              enable,
  input  logic              mode9,
  input  logic              latch_full,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              load
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0] LAST8    = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST9    = BIT_W'(DATA_W);

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BIT_W-1:0]  nb_q, nb_n;
  logic [DATA_W:0]   sh_q, sh_n;
  logic              prev_q, prev_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              b9_q, b9_n, load_q, load_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    nb_n   = nb_q;
    sh_n   = sh_q;
    prev_n = prev_q;
    data_n = data_q;
    b9_n   = b9_q;
    load_n = 1'b0;
    if (tick) begin
      prev_n = rxd_s;
      unique case (st_q)
        RX_IDLE: begin
          if (enable && prev_q && !rxd_s) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_n = '0;
            if (!rxd_s) begin
              st_n = RX_DATA;
              nb_n = '0;
              sh_n = '1;
            end else begin
              st_n = RX_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n = '0;
            sh_n  = {rxd_s, sh_q[DATA_W:1]};
            nb_n  = nb_q + 1'b1;
            if (nb_q == (mode9 ? LAST9 : LAST8)) st_n = RX_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n = '0;
            st_n  = RX_IDLE;
            if (rxd_s && enable && !latch_full) begin
              load_n = 1'b1;
              if (mode9) begin
                data_n = sh_q[DATA_W-1:0];
                b9_n   = sh_q[DATA_W];
              end else begin
                data_n = sh_q[DATA_W:1];
              end
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      nb_q   <= '0;
      sh_q   <= '1;
      prev_q <= 1'b1;
      data_q <= '0;
      b9_q   <= 1'b0;
      load_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      nb_q   <= nb_n;
      sh_q   <= sh_n;
      prev_q <= prev_n;
      data_q <= data_n;
      b9_q   <= b9_n;
      load_q <= load_n;
    end
  end

  assign data = data_q;
  assign bit9 = b9_q;
  assign load = load_q;

  // R10: start bit seen high at mid-bit returns to idle
  a_r10_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && tick && cnt_q == CNT_HALF && rxd_s) |=> (st_q == RX_IDLE));

  // R11: no latch load unless the receiver was enabled
  a_r11_load_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> $past(enable));

  // R9: no load while the latch is still owned by software
  a_r9_no_load_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> !$past(latch_full));

endmodule

// File: rtl/sfr_uart.sv
module sfr_uart
  import sfr_uart_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud16_en,
  input  logic              sfr_sel_data,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  logic ctrl_wr, data_wr;
  logic ti_q, ti_n, ri_q, ri_n, tb9_q, tb9_n, ron_q, ron_n, m9_q, m9_n;
  logic tx_busy, tx_done, rx_load, rx_b9, rxd_s;
  logic [DATA_W-1:0] rx_data;

  assign ctrl_wr = sfr_wr && !sfr_sel_data;
  assign data_wr = sfr_wr &&  sfr_sel_data;

  sfr_uart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  sfr_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud16_en), .load(data_wr),
    .load_data(sfr_wdata), .mode9(m9_q), .bit9(tb9_q),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sfr_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud16_en), .rxd_s(rxd_s),
    .enable(ron_q), .mode9(m9_q), .latch_full(ri_q),
    .data(rx_data), .bit9(rx_b9), .load(rx_load)
  );

  // control fields: software writes, hardware only sets the flags
  always_comb begin
    ti_n  = ti_q;
    ri_n  = ri_q;
    tb9_n = tb9_q;
    ron_n = ron_q;
    m9_n  = m9_q;
    if (ctrl_wr) begin
      ti_n  = sfr_wdata[CB_TXDONE];
      ri_n  = sfr_wdata[CB_RXFULL];
      tb9_n = sfr_wdata[CB_TXB9];
      ron_n = sfr_wdata[CB_RXON];
      m9_n  = sfr_wdata[CB_MODE9];
    end
    if (tx_done) ti_n = 1'b1;
    if (rx_load) ri_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti_q  <= 1'b0;
      ri_q  <= 1'b0;
      tb9_q <= 1'b0;
      ron_q <= 1'b0;
      m9_q  <= 1'b0;
    end else begin
      ti_q  <= ti_n;
      ri_q  <= ri_n;
      tb9_q <= tb9_n;
      ron_q <= ron_n;
      m9_q  <= m9_n;
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_sel_data) begin
      sfr_rdata = rx_data;
    end else begin
      sfr_rdata[CB_TXDONE] = ti_q;
      sfr_rdata[CB_RXFULL] = ri_q;
      sfr_rdata[CB_TXB9]   = tb9_q;
      sfr_rdata[CB_RXB9]   = rx_b9;
      sfr_rdata[CB_RXON]   = ron_q;
      sfr_rdata[CB_MODE9]  = m9_q;
    end
  end

  assign irq = ti_q | ri_q;

  // R5: flags drop only through a control write
  a_r5_txdone_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ti_q && !ctrl_wr) |=> ti_q);
  a_r5_rxfull_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && !ctrl_wr) |=> ri_q);

  // R9: unread byte is never overwritten
  a_r9_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && !ctrl_wr) |=> $stable(rx_data));

  // R4: completion events raise the request one cycle later
  a_r4_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_load) |=> irq);

endmodule

// File: tb/sfr_uart_bench.sv
module sfr_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud16_en = 1'b0;
  logic       sfr_sel_data = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;
  bit quiet_tx = 1'b0;
  int quiet_bad = 0;

  localparam int BIT_CLKS = 64; // 16 ticks of 4 clocks

  always #2 clk = ~clk; // 250 MHz

  sfr_uart u_sfr_uart (
    .clk(clk), .rst_n(rst_n), .baud16_en(baud16_en),
    .sfr_sel_data(sfr_sel_data), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  // oversample tick: one cycle in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud16_en = 1'b1;
      @(negedge clk);
      baud16_en = 1'b0;
    end
  end

  // per-clock model: transmit line must idle high while quiet_tx is set (R12)
  always @(negedge clk) if (quiet_tx && txd !== 1'b1) quiet_bad++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cv(bit ti, bit ri, bit tb9, bit ron, bit m9);
    return {2'b00, m9, ron, 1'b0, tb9, ri, ti};
  endfunction

  task automatic wr_reg(input logic sel, input logic [7:0] v);
    @(negedge clk);
    sfr_sel_data = sel; sfr_wdata = v; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    sfr_sel_data = sel;
    #1 v = sfr_rdata;
  endtask

  task automatic send_rx(input logic [8:0] d, input bit nine, input logic stopv);
    rxd = 1'b0; repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BIT_CLKS) @(negedge clk); end
    if (nine) begin rxd = d[8]; repeat (BIT_CLKS) @(negedge clk); end
    rxd = stopv; repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1; repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic capture_tx(input int n, output logic [10:0] bits);
    int guard = 0;
    bits = '1;
    while (txd === 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    repeat (BIT_CLKS/2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic wait_ti(output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 200; i++) begin
      rd_reg(1'b0, v);
      if (v[0]) break;
    end
  endtask

  initial begin
    logic [7:0]  r;
    logic [10:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd idle", txd, 1);
    chk(irq === 1'b0, "R1 irq low", irq, 0);
    rd_reg(1'b0, r); chk(r === 8'h00, "R1 control reset", r, 8'h00);
    rd_reg(1'b1, r); chk(r === 8'h00, "R1 data reset", r, 8'h00);

    // R6 8-bit receive, R4 irq from RX_FULL
    wr_reg(1'b0, cv(0,0,0,1,0));
    send_rx(9'h03C, 0, 1'b1);
    rd_reg(1'b0, r); chk(r[1] === 1'b1, "R6 RX_FULL set", r, cv(0,1,0,1,0));
    chk(irq === 1'b1, "R4 irq from RX_FULL", irq, 1);
    rd_reg(1'b1, r); chk(r === 8'h3C, "R6 received byte", r, 8'h3C);

    // R9 overrun keeps old byte
    send_rx(9'h081, 0, 1'b1);
    rd_reg(1'b1, r); chk(r === 8'h3C, "R9 latch kept", r, 8'h3C);
    rd_reg(1'b0, r); chk(r[1] === 1'b1, "R9 RX_FULL still set", r[1], 1);

    // R8 second frame arrives while first byte unread
    fork
      send_rx(9'h0C3, 0, 1'b1);
      begin
        repeat (5*BIT_CLKS) @(negedge clk);
        rd_reg(1'b1, r); chk(r === 8'h3C, "R8 read during reception", r, 8'h3C);
        wr_reg(1'b0, cv(0,0,0,1,0));
      end
    join
    rd_reg(1'b1, r); chk(r === 8'hC3, "R8 second byte", r, 8'hC3);
    rd_reg(1'b0, r); chk(r[1] === 1'b1, "R8 RX_FULL set", r[1], 1);

    // R13 bad stop bit
    wr_reg(1'b0, cv(0,0,0,1,0));
    send_rx(9'h055, 0, 1'b0);
    rd_reg(1'b0, r); chk(r[1] === 1'b0, "R13 RX_FULL clear", r[1], 0);
    rd_reg(1'b1, r); chk(r === 8'hC3, "R13 latch unchanged", r, 8'hC3);

    // R10 glitch
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (12*BIT_CLKS) @(negedge clk);
    rd_reg(1'b0, r); chk(r[1] === 1'b0, "R10 glitch ignored", r[1], 0);

    // R7 9-bit receive
    wr_reg(1'b0, cv(0,0,0,1,1));
    send_rx(9'h196, 1, 1'b1);
    rd_reg(1'b1, r); chk(r === 8'h96, "R7 9-bit data", r, 8'h96);
    rd_reg(1'b0, r); chk(r[3] === 1'b1, "R7 RX_BIT9 one", r[3], 1);
    wr_reg(1'b0, cv(0,0,0,1,1));
    send_rx(9'h069, 1, 1'b1);
    rd_reg(1'b1, r); chk(r === 8'h69, "R7 9-bit data b", r, 8'h69);
    rd_reg(1'b0, r); chk(r[3] === 1'b0, "R7 RX_BIT9 zero", r[3], 0);

    // R11 receiver off
    wr_reg(1'b0, cv(0,0,0,0,0));
    send_rx(9'h011, 0, 1'b1);
    rd_reg(1'b0, r); chk(r[1] === 1'b0, "R11 RX_FULL clear", r[1], 0);
    rd_reg(1'b1, r); chk(r === 8'h69, "R11 latch unchanged", r, 8'h69);
    chk(irq === 1'b0, "R11 irq low", irq, 0);

    // R2 8-bit transmit with R12 write during the frame
    wr_reg(1'b1, 8'hA5);
    fork
      capture_tx(10, b);
      begin repeat (3*BIT_CLKS) @(negedge clk); wr_reg(1'b1, 8'h00); end
    join
    chk(b[0] === 1'b0, "R2 start bit", b[0], 0);
    chk(b[8:1] === 8'hA5, "R12 frame unchanged by write", b[8:1], 8'hA5);
    chk(b[9] === 1'b1, "R2 stop bit", b[9], 1);
    wait_ti(r);
    chk(r[0] === 1'b1, "R4 TX_DONE set", r[0], 1);
    chk(irq === 1'b1, "R4 irq from TX_DONE", irq, 1);
    quiet_tx = 1'b1;
    repeat (14*BIT_CLKS) @(negedge clk);
    quiet_tx = 1'b0;
    chk(quiet_bad == 0, "R12 no extra frame", quiet_bad, 0);

    // R5 sticky then cleared by software
    rd_reg(1'b0, r); chk(r[0] === 1'b1, "R5 TX_DONE held", r[0], 1);
    wr_reg(1'b0, cv(0,0,1,0,1));
    rd_reg(1'b0, r); chk(r[0] === 1'b0, "R5 TX_DONE cleared", r[0], 0);
    chk(irq === 1'b0, "R5 irq cleared", irq, 0);

    // R3 9-bit transmit, ninth bit one then zero
    wr_reg(1'b1, 8'h5A);
    capture_tx(11, b);
    chk(b[8:1] === 8'h5A, "R3 data bits", b[8:1], 8'h5A);
    chk(b[9] === 1'b1, "R3 ninth bit one", b[9], 1);
    chk(b[10] === 1'b1, "R3 stop bit", b[10], 1);
    wait_ti(r);
    wr_reg(1'b0, cv(0,0,0,0,1));
    wr_reg(1'b1, 8'h5A);
    capture_tx(11, b);
    chk(b[9] === 1'b0, "R3 ninth bit zero", b[9], 0);
    wait_ti(r);
    chk(r[0] === 1'b1, "R4 TX_DONE after 9-bit frame", r[0], 1);

    if (!done_run) begin
      done_run = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      done_run = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule